// File: doc/BRIEF.md
# Masked Vector Expand Unit

This unit takes a run of scalar elements that were already fetched back to back from memory, together with a per-lane select mask and a fallback vector. It spreads the packed elements over the lanes of a result vector. Each selected lane receives the next packed element in ascending lane order. Each unselected lane keeps the value of the fallback vector in the same lane. The unit also reports how many packed elements the mask used up, so that an upstream address generator can move its read pointer forward by that amount.

Requests arrive with a valid/ready handshake. The result and the used-element count are registered and come out together one cycle after a request is accepted, under their own valid/ready pair. While a result waits unaccepted, the unit holds it steady and refuses new requests. This lets the unit sit directly behind a load buffer. The lane count and the element width are parameters.

Top module: `vec_expand`

## Requirements
- R1: A request accepted on a clock edge (`in_valid` and `in_ready` both high) is presented on `out_data`/`out_used` with `out_valid` high after that edge. `lane_mask` bit i governs result lane i, and lane i occupies bits `[i*EW +: EW]` of every vector port.
- R2: `out_used` equals the number of 1 bits in the accepted `lane_mask`.
- R3: A result lane whose mask bit is 1 carries the packed element whose index equals the number of 1 mask bits in lower lanes. The element at index j sits at bits `[j*EW +: EW]` of `src_data`. For example, with 8 lanes and mask 8'h89, elements 0, 1 and 2 land in lanes 0, 3 and 7, and `out_used` is 3.
- R4: A result lane whose mask bit is 0 carries the same lane of `pass_data`.
- R5: With an all-ones mask, lane i carries packed element i and `out_used` equals the lane count.
- R6: With an all-zeros mask, `out_used` is 0 and `out_data` equals `pass_data`.
- R7: Packed elements at indices greater than or equal to the used count have no effect on `out_data` or `out_used`.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data`, `out_used` and `out_valid` do not change.
- R9: After reset, `out_valid` is 0, `out_used` is 0 and `out_data` is 0.
- R10: With `out_ready` held high, a new request is accepted on every clock edge, and each result appears one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| lane_mask | input | LANES | Per-lane select; bit i for lane i |
| src_data | input | LANES*EW | Packed elements; element j at bits j*EW |
| pass_data | input | LANES*EW | Fallback vector for unselected lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANES*EW | Expanded result vector |
| out_used | output | $clog2(LANES+1) | Number of packed elements used |

## Verification
The hardest case to reach from the ports is a stall in which a second request is already waiting while the first result is held. The register must keep the old result, and the waiting request must be taken on exactly the edge where the consumer releases. The bench creates this case by dropping `out_ready`, issuing one request, and then presenting a different one. It checks that `in_ready` stays low and the output stays frozen, then raises `out_ready` and checks that the second result follows. Showing that unused packed elements are ignored takes two requests with the same mask and fallback vector but different garbage above the used count; the bench compares their results.

// File: rtl/vec_expand.sv
module vec_expand #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [LANES*EW-1:0] src_data,
  input  logic [LANES*EW-1:0] pass_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*EW-1:0] out_data,
  output logic [CW-1:0]       out_used
);

  logic [LANES*EW-1:0] nxt_data;
  logic [CW-1:0]       rank;

  assign in_ready = !out_valid || out_ready;

  always_comb begin
    rank = '0;
    nxt_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_mask[i])
        nxt_data[i*EW +: EW] = src_data[int'(rank)*EW +: EW];
      else
        nxt_data[i*EW +: EW] = pass_data[i*EW +: EW];
      rank = rank + CW'(lane_mask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_used  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
      out_used  <= rank;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

module vec_expand_chk #(
  parameter int LANES = 8,
  parameter int EW    = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES-1:0]    lane_mask,
  input logic [LANES*EW-1:0] src_data,
  input logic [LANES*EW-1:0] pass_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*EW-1:0] out_data,
  input logic [CW-1:0]       out_used
);

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> out_valid); // R1
  AST_USED_IS_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> out_used == CW'($countones($past(lane_mask)))); // R2
  AST_EMPTY_MASK_PASSES: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready && lane_mask == '0 |=> out_data == $past(pass_data)); // R6
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |-> !in_ready); // R8
  AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_used)); // R8
  AST_USED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_used <= CW'(LANES)); // R2

endmodule

bind vec_expand vec_expand_chk #(.LANES(LANES), .EW(EW)) u_vec_expand_chk (.*);

// File: tb/test_vec_expand.sv
module test_vec_expand;
  localparam int LANES = 8;
  localparam int EW    = 16;
  localparam int CW    = $clog2(LANES + 1);
  localparam int VW    = LANES * EW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [LANES-1:0] lane_mask = '0;
  logic [VW-1:0] src_data = '0, pass_data = '0;
  logic in_ready, out_valid;
  logic [VW-1:0] out_data;
  logic [CW-1:0] out_used;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_expand #(.LANES(LANES), .EW(EW)) i_vec_expand (.*);

  function automatic logic [VW-1:0] model_data(input logic [LANES-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] p);
    logic [VW-1:0] r;
    int k;
    k = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        r[i*EW +: EW] = s[k*EW +: EW];
        k++;
      end else r[i*EW +: EW] = p[i*EW +: EW];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] model_used(input logic [LANES-1:0] m);
    int k;
    k = 0;
    for (int i = 0; i < LANES; i++) if (m[i]) k++;
    return CW'(k);
  endfunction

  function automatic logic [VW-1:0] fill(input logic [EW-1:0] base);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*EW +: EW] = base + EW'(i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [LANES-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] p);
    @(negedge clk);
    lane_mask = m; src_data = s; pass_data = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_result(input string req, input logic [LANES-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] p);
    chk({req, " valid"}, VW'(out_valid), VW'(1));
    chk({req, " used"}, VW'(out_used), VW'(model_used(m)));
    chk({req, " data"}, out_data, model_data(m, s, p));
  endtask

  task automatic t_reset();
    chk("R9 valid", VW'(out_valid), '0);
    chk("R9 used", VW'(out_used), '0);
    chk("R9 data", out_data, '0);
  endtask

  task automatic t_example();
    logic [VW-1:0] s = fill(16'hA000), p = fill(16'h5000);
    send(8'h89, s, p);
    check_result("R1 R2 R3", 8'h89, s, p);
    chk("R3 lane0", VW'(out_data[0*EW +: EW]), VW'(16'hA000));
    chk("R3 lane3", VW'(out_data[3*EW +: EW]), VW'(16'hA001));
    chk("R3 lane7", VW'(out_data[7*EW +: EW]), VW'(16'hA002));
    chk("R4 lane5", VW'(out_data[5*EW +: EW]), VW'(16'h5005));
    chk("R2 used3", VW'(out_used), VW'(3));
  endtask

  task automatic t_patterns();
    logic [LANES-1:0] ms [4] = '{8'h01, 8'h80, 8'hAA, 8'h7E};
    for (int n = 0; n < 4; n++) begin
      logic [VW-1:0] s = fill(16'h1100 + 16'(n) * 16'h100), p = fill(16'hF000);
      send(ms[n], s, p);
      check_result("R3 R4", ms[n], s, p);
    end
  endtask

  task automatic t_all_ones();
    logic [VW-1:0] s = fill(16'hC0DE), p = fill(16'h0BAD);
    send('1, s, p);
    chk("R5 data", out_data, s);
    chk("R5 used", VW'(out_used), VW'(LANES));
  endtask

  task automatic t_all_zeros();
    logic [VW-1:0] s = fill(16'h7700), p = fill(16'h3300);
    send('0, s, p);
    chk("R6 data", out_data, p);
    chk("R6 used", VW'(out_used), '0);
  endtask

  task automatic t_ignore_tail();
    logic [VW-1:0] s1 = fill(16'h2200), s2, p = fill(16'h9900), first;
    s2 = s1;
    for (int j = 3; j < LANES; j++) s2[j*EW +: EW] = 16'hDEAD;
    send(8'h34, s1, p);
    first = out_data;
    send(8'h34, s2, p);
    chk("R7 data", out_data, first);
    chk("R7 used", VW'(out_used), VW'(3));
  endtask

  task automatic t_stall();
    logic [VW-1:0] sa = fill(16'h4400), sb = fill(16'h6600), p = fill(16'h0100);
    @(negedge clk);
    out_ready = 1'b0;
    lane_mask = 8'h0F; src_data = sa; pass_data = p; in_valid = 1'b1;
    @(negedge clk);
    lane_mask = 8'hF0; src_data = sb;
    chk("R8 ready low", VW'(in_ready), '0);
    @(negedge clk);
    chk("R8 held data", out_data, model_data(8'h0F, sa, p));
    chk("R8 held valid", VW'(out_valid), VW'(1));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R8 release", 8'hF0, sb, p);
  endtask

  task automatic t_streaming();
    logic [VW-1:0] p = fill(16'h0);
    @(negedge clk);
    in_valid = 1'b1; pass_data = p;
    for (int n = 0; n < 4; n++) begin
      lane_mask = LANES'(8'h11 << n);
      src_data = fill(16'h8000 + 16'(n) * 16'h10);
      chk("R10 ready", VW'(in_ready), VW'(1));
      @(negedge clk);
      check_result("R10", LANES'(8'h11 << n), fill(16'h8000 + 16'(n) * 16'h10), p);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_patterns();
    t_all_ones();
    t_all_zeros();
    t_ignore_tail();
    t_stall();
    t_streaming();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule